// File: doc/BRIEF.md
# Multiplexed-Bus Static Memory with Chained Read Enable

This block is a 64-word by 8-bit static memory meant to hang directly off a processor that time-shares its address pins. One address line has two roles. A strobe input captures it as a select qualifier on the strobe's falling edge. Afterwards the same line carries the sixth address bit. Two static enable inputs must also agree before the memory reads or writes. Separate active-low read and write strobes control access, and the write strobe wins when both are low, so a single read/write line can drive the pair.

A chain-enable output lets a second read-only device share the read path. That output is high whenever this memory is selected. It drops low only when this memory is deselected while the read strobe is low, and that low selects the neighbour. The three-state data bus is modelled as separate write-data and read-data buses plus an output enable. All inputs are sampled in one clock domain, and the strobe edge is found against the strobe's value on the previous clock. Read data are combinational from the present address.

Tying the strobe high turns the capture off. The qualifier then counts as satisfied, and the shared line acts purely as address bit 5.

Top module: `mux_sram_chain`

## Requirements
- R1: The word index is {addr_sel, addr_lo[4:0]}, with addr_sel as bit 5. This gives 64 independent 8-bit words.
- R2: On a clock edge where strobe is 0 and strobe was 1 on the previous edge, the qualifier takes the value of addr_sel. On every other edge the qualifier keeps its value.
- R3: While strobe is 1, the qualifier counts as satisfied whatever was captured, and addr_sel acts only as address bit 5.
- R4: The memory is selected only when the qualifier is satisfied, en_a is 1 and en_b_n is 0. When it is not selected, a write leaves the stored contents unchanged and rdata_oe stays 0.
- R5: On each clock edge where the memory is selected and wr_n is 0, wdata is stored at the addressed word. While wr_n is 0, rdata_oe is 0 even if rd_n is also 0.
- R6: chain_en is 1 whenever the memory is selected.
- R7: chain_en is 0 exactly when the memory is deselected and rd_n is 0. Otherwise it is 1.
- R8: rdata_oe is 1 exactly when the memory is selected, rd_n is 0 and wr_n is 1. rdata then shows the stored word at the current address in the same cycle. rdata is 0 whenever rdata_oe is 0.
- R9: Reset clears both the captured qualifier and the strobe history. While strobe stays 0 after reset, the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the select logic |
| addr_lo | input | 5 | Low address bits 4..0 |
| addr_sel | input | 1 | Shared select qualifier / address bit 5 |
| strobe | input | 1 | Capture strobe; held high disables capture |
| en_a | input | 1 | Static enable, must be 1 |
| en_b_n | input | 1 | Static enable, must be 0 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, overrides read |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus, 0 when not driving |
| rdata_oe | output | 1 | Bus drive enable |
| chain_en | output | 1 | Chain enable for the next device on the read path |

## Verification
A wrong captured qualifier appears at the ports in the first cycle where the strobe is low and a read is pending. The failure shows either as chain_en dropping while the memory should answer, or as rdata_oe rising while the neighbour should. A lost or misdirected write stays hidden until that word is read. For that reason every word is read back after all are written, and after each ignored write. The bench compares all three outputs against a behavioural model on every clock, so a fault shows in the cycle it is made.

// File: rtl/mux_sram_pkg.sv
package mux_sram_pkg;

  parameter int unsigned LO_W_DEF   = 5;
  parameter int unsigned DATA_W_DEF = 8;

  // The shared line always sits above the low address bits.
  function automatic logic [LO_W_DEF:0] word_index(input logic hi, input logic [LO_W_DEF-1:0] lo);
    return {hi, lo};
  endfunction

  // Select rule: the qualifier must be satisfied, the first enable high and the second low.
  function automatic logic select_rule(input logic qual, input logic ena, input logic enb_n);
    return qual & ena & ~enb_n;
  endfunction

endpackage

// File: rtl/msc_select_latch.sv
module msc_select_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic line,
  output logic qual,
  output logic fall_seen
);

  logic strobe_q;
  logic cap_q;

  assign fall_seen = strobe_q & ~strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cap_q    <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (fall_seen) cap_q <= line;
    end
  end

  // A strobe held high makes the capture transparent, so the qualifier counts as satisfied.
  assign qual = strobe | cap_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_seen |=> (cap_q == $past(line)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_seen |=> $stable(cap_q));

endmodule

// File: rtl/msc_store.sv
module msc_store #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign word = mem[addr];

  assert_write_lands_R5: assert property (@(posedge clk)
    we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/msc_port_ctl.sv
module msc_port_ctl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] word,
  output logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              chain_en
);

  logic rd_active;

  assign wr_en     = selected & ~wr_n;
  assign rd_active = selected & ~rd_n & wr_n;
  assign rdata_oe  = rd_active;
  assign rdata     = rd_active ? word : '0;
  assign chain_en  = ~(~selected & ~rd_n);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !rdata_oe);

  assert_chain_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> chain_en);

  assert_drive_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!rd_n && selected));

  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

endmodule

// File: rtl/mux_sram_chain.sv
module mux_sram_chain
  import mux_sram_pkg::*;
#(
  parameter int unsigned LO_W   = LO_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   addr_lo,
  input  logic              addr_sel,
  input  logic              strobe,
  input  logic              en_a,
  input  logic              en_b_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              chain_en
);

  localparam int unsigned ADDR_W = LO_W + 1;

  logic              qual;
  logic              fall_seen;
  logic              selected;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;

  assign addr     = {addr_sel, addr_lo};
  assign selected = qual & en_a & ~en_b_n;

  msc_select_latch u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .line      (addr_sel),
    .qual      (qual),
    .fall_seen (fall_seen)
  );

  msc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .word  (word)
  );

  msc_port_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .selected (selected),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .word     (word),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .chain_en (chain_en)
  );

  assert_chain_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |-> (!rd_n && !rdata_oe));

  assert_enables_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a || en_b_n) |-> (!rdata_oe && chain_en == rd_n));

endmodule

// File: tb/test_mux_sram_chain.sv
module test_mux_sram_chain;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr_lo = '0;
  logic       addr_sel = 1'b0;
  logic       strobe = 1'b0;
  logic       en_a = 1'b0;
  logic       en_b_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic       chain_en;

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0] m_mem [64];
  logic       m_cap = 1'b0;
  logic       m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_sram_chain i_mux_sram_chain (
    .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_sel(addr_sel),
    .strobe(strobe), .en_a(en_a), .en_b_n(en_b_n), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .chain_en(chain_en)
  );

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 29 + 71 + salt * 13) ^ 8'h5A);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; compare with the behavioural model mid-cycle, then advance the model.
  task automatic cyc(input logic s, input logic line, input int lo, input logic ea, input logic ebn,
                     input logic r, input logic w, input logic [7:0] d, input string tag);
    logic q, sel, e_oe, e_ch;
    logic [7:0] e_rd;
    int idx;
    #1;
    strobe = s; addr_sel = line; addr_lo = 5'(lo); en_a = ea; en_b_n = ebn;
    rd_n = r; wr_n = w; wdata = d;
    @(negedge clk);
    idx  = {line, 5'(lo)};
    q    = s || m_cap;
    sel  = q && ea && !ebn;
    e_oe = sel && !r && w;
    e_rd = e_oe ? m_mem[idx] : 8'h00;
    e_ch = !(!sel && !r);
    check(tag, "rdata_oe", int'(rdata_oe), int'(e_oe));
    check(tag, "rdata", int'(rdata), int'(e_rd));
    check(tag, "chain_en", int'(chain_en), int'(e_ch));
    @(posedge clk);
    if (sel && !w) m_mem[idx] = d;
    if (m_prev && !s) m_cap = line;
    m_prev = s;
  endtask

  task automatic do_reset();
    #1;
    rst_n = 1'b0; strobe = 1'b0; rd_n = 1'b0; wr_n = 1'b1; en_a = 1'b1; en_b_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9: after reset, strobe low -> deselected: no drive, chain low on read
    check("R9", "rdata_oe in reset", int'(rdata_oe), 0);
    check("R9", "chain_en in reset", int'(chain_en), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_cap = 1'b0; m_prev = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 8'h00;
    do_reset();
    // R9: strobe stays low, still deselected
    cyc(0, 1, 3, 1, 0, 0, 1, 8'h00, "R9");

    // R1 R3 R5: strobe held high, fill all 64 words
    for (int a = 0; a < 64; a++) cyc(1, a[5], a % 32, 1, 0, 1, 0, pat(a, 0), "R5");
    // R1 R8: read every word back
    for (int a = 0; a < 64; a++) cyc(1, a[5], a % 32, 1, 0, 0, 1, 8'h00, "R8");

    // R5: write overrides read
    cyc(1, 0, 10, 1, 0, 0, 0, 8'hC3, "R5");
    cyc(1, 0, 10, 1, 0, 0, 1, 8'h00, "R5");

    // R4: en_a low blocks write, chain low on read
    cyc(1, 0, 3, 0, 0, 1, 0, 8'hEE, "R4");
    cyc(1, 0, 3, 0, 0, 0, 1, 8'h00, "R7");
    cyc(1, 0, 3, 1, 0, 0, 1, 8'h00, "R4");
    // R4: en_b_n high blocks write
    cyc(1, 1, 7, 1, 1, 1, 0, 8'h11, "R4");
    cyc(1, 1, 7, 1, 1, 0, 1, 8'h00, "R7");
    cyc(1, 1, 7, 1, 0, 0, 1, 8'h00, "R4");
    // R6 R7: idle selected and deselected, rd_n high
    cyc(1, 0, 0, 1, 0, 1, 1, 8'h00, "R6");
    cyc(1, 0, 0, 0, 1, 1, 1, 8'h00, "R7");

    // R2: capture high on falling strobe, then line carries address bit 5
    cyc(1, 1, 0, 1, 0, 1, 1, 8'h00, "R2");
    cyc(0, 1, 0, 1, 0, 1, 1, 8'h00, "R2");
    for (int a = 0; a < 64; a += 5) cyc(0, a[5], a % 32, 1, 0, 0, 1, 8'h00, "R2");
    cyc(0, 1, 21, 1, 0, 1, 0, 8'h9D, "R5");
    cyc(0, 1, 21, 1, 0, 0, 1, 8'h00, "R1");

    // R2: capture low -> deselected, writes ignored, chain low on read
    cyc(1, 0, 0, 1, 0, 1, 1, 8'h00, "R2");
    cyc(0, 0, 0, 1, 0, 1, 1, 8'h00, "R2");
    cyc(0, 1, 4, 1, 0, 0, 1, 8'h00, "R7");
    cyc(0, 1, 4, 1, 0, 1, 0, 8'h77, "R4");
    // line toggles with strobe low: no edge, qualifier held
    for (int k = 0; k < 6; k++) cyc(0, k[0], 4 + k, 1, 0, 0, 1, 8'h00, "R2");
    // R3: strobe high again, word 36 unchanged
    cyc(1, 1, 4, 1, 0, 0, 1, 8'h00, "R3");

    // R9: reset mid-run clears qualifier
    cyc(1, 1, 0, 1, 0, 1, 1, 8'h00, "R2");
    cyc(0, 1, 0, 1, 0, 1, 1, 8'h00, "R2");
    do_reset();
    cyc(0, 1, 8, 1, 0, 0, 1, 8'h00, "R9");
    cyc(0, 1, 8, 1, 0, 1, 0, 8'h42, "R9");
    cyc(1, 1, 8, 1, 0, 0, 1, 8'h00, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule